// File: doc/BRIEF.md
# Renamed Operand Fetch Unit

This block sits between instruction decode and the issue buffers of an out-of-order core. For each decoded instruction it takes two source register indices and resolves each one into either a finished value or the reorder-buffer tag of the result still in flight. The resolved pair is registered and presented one cycle later, so a dispatch stage can write it straight into a reservation station or load/store queue entry.

The block holds the architectural register values and the per-register rename state. It also holds a small per-tag result store. This store records every result broadcast and is cleared when a tag is handed out again. Within the cycle of the lookup, it also forwards from the execution broadcast, the load broadcast and the retiring entry. A result therefore never falls into the gap between being produced and becoming visible in stored state.

The same ports that carry rename and retirement updates also update the internal state. A source read in a given cycle always sees the state as it was before that cycle's updates.

Top module: `opnd_fetch`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, no register is renamed and every register reads as value 0 with ready 1.
- R2: A source register that is not renamed resolves to its stored register value with ready 1 and tag field 0.
- R3: A renamed source whose tag has a recorded result resolves to that result (ready 1, tag field 0). A tag is recorded by an execution or load broadcast and forgotten when the tag is allocated again by a rename.
- R4: A renamed source whose tag equals the tag of a valid execution broadcast in the same cycle resolves to the broadcast value.
- R5: A renamed source whose tag equals the tag of a valid load broadcast in the same cycle resolves to the load value.
- R6: A renamed source whose tag equals the tag of a valid retirement in the same cycle resolves to the retiring value.
- R7: Source precedence for a renamed register is fixed, highest first: recorded result, execution broadcast, load broadcast, retirement.
- R8: When no source matches, the operand comes out with ready 0, value 0, and the pending tag. Tags are compared for exact equality over all TAG_W bits.
- R9: Register index 0 always resolves to value 0, ready 1, tag 0. Renames and retirements that name register 0 are ignored.
- R10: A rename presented in the same cycle as a request does not affect that request. Later requests see the register as pending on the new tag.
- R11: Retirement writes the register value. It clears the pending state only when the retiring tag equals the register's current tag and no rename of the same register occurs in that cycle; otherwise later requests still wait on the newer tag.
- R12: Outputs change exactly one cycle after a request. `out_valid` follows `req_valid` by one cycle, and operand outputs hold their values in cycles without a request.

Top module ports, in list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Resolve request this cycle |
| req_rs1 | input | 5 | First source register index |
| req_rs2 | input | 5 | Second source register index |
| ren_valid | input | 1 | Rename: allocate tag and map destination |
| ren_rd | input | 5 | Destination register being renamed |
| ren_tag | input | 4 | Newly allocated reorder-buffer tag |
| ex_valid | input | 1 | Execution result broadcast valid |
| ex_tag | input | 4 | Execution result tag |
| ex_val | input | 32 | Execution result value |
| ld_valid | input | 1 | Load result broadcast valid |
| ld_tag | input | 4 | Load result tag |
| ld_val | input | 32 | Load result value |
| cmt_valid | input | 1 | Retirement valid |
| cmt_rd | input | 5 | Retiring destination register |
| cmt_tag | input | 4 | Retiring tag |
| cmt_val | input | 32 | Retiring value |
| out_valid | output | 1 | Resolved operands valid |
| out_rdy1 | output | 1 | First operand holds a value |
| out_val1 | output | 32 | First operand value |
| out_tag1 | output | 4 | First operand pending tag |
| out_rdy2 | output | 1 | Second operand holds a value |
| out_val2 | output | 32 | Second operand value |
| out_tag2 | output | 4 | Second operand pending tag |

## Verification
The bench uses the default parameters: 32-bit values, 32 registers and a 4-bit tag. With only sixteen tags, random renaming reuses tags within a few dozen cycles, which exercises the clearing of recorded results on reallocation and stale-tag retirements. Random register indices are drawn from the lower sixteen registers, so register 0, repeated renames of one register, and retirement colliding with a rename of the same register all occur often. Directed cycles set every bypass source to the same tag at once to pin down the precedence order.

// File: rtl/opf_pkg.sv
package opf_pkg;

  // Where a resolved operand came from; used for selection and checking.
  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_RF,
    SRC_ROB,
    SRC_EX,
    SRC_LD,
    SRC_CMT,
    SRC_WAIT
  } opf_src_e;

endpackage

// File: rtl/opf_regstate.sv
module opf_regstate #(
  parameter int XLEN   = 32,
  parameter int NREG   = 32,
  parameter int TAG_W  = 4,
  parameter int RPORTS = 2,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] rd_idx  [RPORTS],
  output logic [XLEN-1:0]   rd_val  [RPORTS],
  output logic              rd_busy [RPORTS],
  output logic [TAG_W-1:0]  rd_tag  [RPORTS],
  input  logic              cmt_valid,
  input  logic [RIDX_W-1:0] cmt_rd,
  input  logic [TAG_W-1:0]  cmt_tag,
  input  logic [XLEN-1:0]   cmt_val,
  input  logic              ren_valid,
  input  logic [RIDX_W-1:0] ren_rd,
  input  logic [TAG_W-1:0]  ren_tag
);

  logic [XLEN-1:0]  rf_q   [NREG];
  logic [NREG-1:0]  busy_q;
  logic [TAG_W-1:0] tag_q  [NREG];

  logic cmt_we, ren_we, same_rd, cmt_clear;

  assign cmt_we    = cmt_valid && (cmt_rd != '0);
  assign ren_we    = ren_valid && (ren_rd != '0);
  assign same_rd   = ren_we && (ren_rd == cmt_rd);
  assign cmt_clear = cmt_we && busy_q[cmt_rd] && (tag_q[cmt_rd] == cmt_tag) && !same_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        rf_q[i]  <= '0;
        tag_q[i] <= '0;
      end
      busy_q <= '0;
    end else begin
      if (cmt_we)    rf_q[cmt_rd]   <= cmt_val;
      if (cmt_clear) busy_q[cmt_rd] <= 1'b0;
      if (ren_we) begin
        busy_q[ren_rd] <= 1'b1;
        tag_q[ren_rd]  <= ren_tag;
      end
    end
  end

  for (genvar p = 0; p < RPORTS; p++) begin : g_rd
    assign rd_val[p]  = rf_q[rd_idx[p]];
    assign rd_busy[p] = busy_q[rd_idx[p]];
    assign rd_tag[p]  = tag_q[rd_idx[p]];
  end

  p_rename_marks_r10: assert property (@(posedge clk) disable iff (rst)
    ren_we |=> busy_q[$past(ren_rd)] && (tag_q[$past(ren_rd)] == $past(ren_tag)));

  p_commit_frees_r11: assert property (@(posedge clk) disable iff (rst)
    (cmt_we && busy_q[cmt_rd] && (tag_q[cmt_rd] == cmt_tag) && !(ren_we && ren_rd == cmt_rd))
    |=> !busy_q[$past(cmt_rd)]);

  p_commit_keeps_new_r11: assert property (@(posedge clk) disable iff (rst)
    (cmt_we && ren_we && (ren_rd == cmt_rd)) |=> busy_q[$past(cmt_rd)]);

  p_commit_writes_r11: assert property (@(posedge clk) disable iff (rst)
    cmt_we |=> (rf_q[$past(cmt_rd)] == $past(cmt_val)));

endmodule

// File: rtl/opf_result_mirror.sv
module opf_result_mirror #(
  parameter int XLEN   = 32,
  parameter int TAG_W  = 4,
  parameter int RPORTS = 2,
  localparam int NTAG = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_valid,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             ex_valid,
  input  logic [TAG_W-1:0] ex_tag,
  input  logic [XLEN-1:0]  ex_val,
  input  logic             ld_valid,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [XLEN-1:0]  ld_val,
  input  logic [TAG_W-1:0] rd_tag [RPORTS],
  output logic             rd_rdy [RPORTS],
  output logic [XLEN-1:0]  rd_val [RPORTS]
);

  logic [NTAG-1:0] rdy_q;
  logic [XLEN-1:0] val_q [NTAG];

  // Ready flags: reset, set by broadcasts, cleared by reallocation.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= '0;
    end else begin
      if (ld_valid)    rdy_q[ld_tag]    <= 1'b1;
      if (ex_valid)    rdy_q[ex_tag]    <= 1'b1;
      if (alloc_valid) rdy_q[alloc_tag] <= 1'b0;
    end
  end

  // Value storage: no reset, readable only behind a ready flag.
  always_ff @(posedge clk) begin
    if (ld_valid) val_q[ld_tag] <= ld_val;
    if (ex_valid) val_q[ex_tag] <= ex_val;
  end

  for (genvar p = 0; p < RPORTS; p++) begin : g_rd
    assign rd_rdy[p] = rdy_q[rd_tag[p]];
    assign rd_val[p] = val_q[rd_tag[p]];
  end

  p_ex_records_r3: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !(alloc_valid && alloc_tag == ex_tag))
    |=> rdy_q[$past(ex_tag)] && (val_q[$past(ex_tag)] == $past(ex_val)));

  p_ld_records_r3: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !ex_valid && !(alloc_valid && alloc_tag == ld_tag))
    |=> rdy_q[$past(ld_tag)] && (val_q[$past(ld_tag)] == $past(ld_val)));

  p_alloc_clears_r3: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |=> !rdy_q[$past(alloc_tag)]);

endmodule

// File: rtl/opf_src_select.sv
module opf_src_select
  import opf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int TAG_W  = 4,
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] rs,
  input  logic              busy,
  input  logic [TAG_W-1:0]  tag,
  input  logic [XLEN-1:0]   rf_val,
  input  logic              mir_rdy,
  input  logic [XLEN-1:0]   mir_val,
  input  logic              ex_valid,
  input  logic [TAG_W-1:0]  ex_tag,
  input  logic [XLEN-1:0]   ex_val,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [XLEN-1:0]   ld_val,
  input  logic              cmt_valid,
  input  logic [TAG_W-1:0]  cmt_tag,
  input  logic [XLEN-1:0]   cmt_val,
  output logic              rdy,
  output logic [XLEN-1:0]   val,
  output logic [TAG_W-1:0]  qtag,
  output opf_src_e          src
);

  always_comb begin
    rdy  = 1'b1;
    val  = '0;
    qtag = '0;
    src  = SRC_ZERO;
    if (rs == '0) begin
      src = SRC_ZERO;
    end else if (!busy) begin
      src = SRC_RF;
      val = rf_val;
    end else if (mir_rdy) begin
      src = SRC_ROB;
      val = mir_val;
    end else if (ex_valid && (ex_tag == tag)) begin
      src = SRC_EX;
      val = ex_val;
    end else if (ld_valid && (ld_tag == tag)) begin
      src = SRC_LD;
      val = ld_val;
    end else if (cmt_valid && (cmt_tag == tag)) begin
      src = SRC_CMT;
      val = cmt_val;
    end else begin
      src  = SRC_WAIT;
      rdy  = 1'b0;
      qtag = tag;
    end
  end

endmodule

// File: rtl/opnd_fetch.sv
module opnd_fetch
  import opf_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int TAG_W = 4,
  localparam int RIDX_W = $clog2(NREG),
  localparam int NSRC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [RIDX_W-1:0] req_rs1,
  input  logic [RIDX_W-1:0] req_rs2,
  input  logic              ren_valid,
  input  logic [RIDX_W-1:0] ren_rd,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              ex_valid,
  input  logic [TAG_W-1:0]  ex_tag,
  input  logic [XLEN-1:0]   ex_val,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [XLEN-1:0]   ld_val,
  input  logic              cmt_valid,
  input  logic [RIDX_W-1:0] cmt_rd,
  input  logic [TAG_W-1:0]  cmt_tag,
  input  logic [XLEN-1:0]   cmt_val,
  output logic              out_valid,
  output logic              out_rdy1,
  output logic [XLEN-1:0]   out_val1,
  output logic [TAG_W-1:0]  out_tag1,
  output logic              out_rdy2,
  output logic [XLEN-1:0]   out_val2,
  output logic [TAG_W-1:0]  out_tag2
);

  logic [RIDX_W-1:0] rs_idx   [NSRC];
  logic [XLEN-1:0]   rf_val   [NSRC];
  logic              rf_busy  [NSRC];
  logic [TAG_W-1:0]  rf_tag   [NSRC];
  logic              mir_rdy  [NSRC];
  logic [XLEN-1:0]   mir_val  [NSRC];
  logic              sel_rdy  [NSRC];
  logic [XLEN-1:0]   sel_val  [NSRC];
  logic [TAG_W-1:0]  sel_tag  [NSRC];
  opf_src_e          sel_src  [NSRC];
  logic              rdy_q    [NSRC];
  logic [XLEN-1:0]   val_q    [NSRC];
  logic [TAG_W-1:0]  tag_q    [NSRC];
  logic              valid_q;

  assign rs_idx[0] = req_rs1;
  assign rs_idx[1] = req_rs2;

  opf_regstate #(
    .XLEN(XLEN), .NREG(NREG), .TAG_W(TAG_W), .RPORTS(NSRC)
  ) u_regs (
    .clk(clk), .rst(rst),
    .rd_idx(rs_idx), .rd_val(rf_val), .rd_busy(rf_busy), .rd_tag(rf_tag),
    .cmt_valid(cmt_valid), .cmt_rd(cmt_rd), .cmt_tag(cmt_tag), .cmt_val(cmt_val),
    .ren_valid(ren_valid), .ren_rd(ren_rd), .ren_tag(ren_tag)
  );

  opf_result_mirror #(
    .XLEN(XLEN), .TAG_W(TAG_W), .RPORTS(NSRC)
  ) u_mirror (
    .clk(clk), .rst(rst),
    .alloc_valid(ren_valid), .alloc_tag(ren_tag),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .ex_val(ex_val),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_val(ld_val),
    .rd_tag(rf_tag), .rd_rdy(mir_rdy), .rd_val(mir_val)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    opf_src_select #(
      .XLEN(XLEN), .TAG_W(TAG_W), .RIDX_W(RIDX_W)
    ) u_sel (
      .rs(rs_idx[s]), .busy(rf_busy[s]), .tag(rf_tag[s]), .rf_val(rf_val[s]),
      .mir_rdy(mir_rdy[s]), .mir_val(mir_val[s]),
      .ex_valid(ex_valid), .ex_tag(ex_tag), .ex_val(ex_val),
      .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_val(ld_val),
      .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_val(cmt_val),
      .rdy(sel_rdy[s]), .val(sel_val[s]), .qtag(sel_tag[s]), .src(sel_src[s])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rdy_q[s] <= 1'b0;
        val_q[s] <= '0;
        tag_q[s] <= '0;
      end else if (req_valid) begin
        rdy_q[s] <= sel_rdy[s];
        val_q[s] <= sel_val[s];
        tag_q[s] <= sel_tag[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= req_valid;
  end

  assign out_valid = valid_q;
  assign out_rdy1  = rdy_q[0];
  assign out_val1  = val_q[0];
  assign out_tag1  = tag_q[0];
  assign out_rdy2  = rdy_q[1];
  assign out_val2  = val_q[1];
  assign out_tag2  = tag_q[1];

  p_valid_follows_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  p_valid_drops_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(out_val1) && $stable(out_tag1) && $stable(out_rdy1)
                && $stable(out_val2) && $stable(out_tag2) && $stable(out_rdy2));

  p_x0_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_rs1 == '0) |=> out_rdy1 && (out_val1 == '0) && (out_tag1 == '0));

  p_wait_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_rdy1) |-> (out_val1 == '0));

  p_ex_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sel_src[0] == SRC_EX) |=> out_rdy1 && (out_val1 == $past(ex_val)));

  p_ld_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sel_src[1] == SRC_LD) |=> out_rdy2 && (out_val2 == $past(ld_val)));

  p_cmt_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sel_src[0] == SRC_CMT) |=> out_rdy1 && (out_val1 == $past(cmt_val)));

endmodule

// File: tb/tb_opnd_fetch.sv
module tb_opnd_fetch;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0;
  logic [4:0]  req_rs1 = 0, req_rs2 = 0;
  logic        ren_valid = 0;
  logic [4:0]  ren_rd = 0;
  logic [3:0]  ren_tag = 0;
  logic        ex_valid = 0;
  logic [3:0]  ex_tag = 0;
  logic [31:0] ex_val = 0;
  logic        ld_valid = 0;
  logic [3:0]  ld_tag = 0;
  logic [31:0] ld_val = 0;
  logic        cmt_valid = 0;
  logic [4:0]  cmt_rd = 0;
  logic [3:0]  cmt_tag = 0;
  logic [31:0] cmt_val = 0;
  logic        out_valid, out_rdy1, out_rdy2;
  logic [31:0] out_val1, out_val2;
  logic [3:0]  out_tag1, out_tag2;

  always #10 clk = ~clk;

  opnd_fetch dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_rs1(req_rs1), .req_rs2(req_rs2),
    .ren_valid(ren_valid), .ren_rd(ren_rd), .ren_tag(ren_tag),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .ex_val(ex_val),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_val(ld_val),
    .cmt_valid(cmt_valid), .cmt_rd(cmt_rd), .cmt_tag(cmt_tag), .cmt_val(cmt_val),
    .out_valid(out_valid), .out_rdy1(out_rdy1), .out_val1(out_val1), .out_tag1(out_tag1),
    .out_rdy2(out_rdy2), .out_val2(out_val2), .out_tag2(out_tag2)
  );

  // Reference model state
  logic [31:0] rf_m  [32];
  logic        busy_m [32];
  logic [3:0]  tag_m [32];
  logic        rdy_m [16];
  logic [31:0] val_m [16];

  logic [73:0] exp_q [$];
  string       req_q [$];
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input logic [73:0] act, input logic [73:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {rdy, val[31:0], tag[3:0]}
  function automatic logic [36:0] resolve(input logic [4:0] rs);
    logic [3:0] t;
    if (rs == 0) return {1'b1, 32'h0, 4'h0};
    if (!busy_m[rs]) return {1'b1, rf_m[rs], 4'h0};
    t = tag_m[rs];
    if (rdy_m[t]) return {1'b1, val_m[t], 4'h0};
    if (ex_valid && ex_tag == t) return {1'b1, ex_val, 4'h0};
    if (ld_valid && ld_tag == t) return {1'b1, ld_val, 4'h0};
    if (cmt_valid && cmt_tag == t) return {1'b1, cmt_val, 4'h0};
    return {1'b0, 32'h0, t};
  endfunction

  task automatic model_update();
    if (ld_valid) begin rdy_m[ld_tag] = 1'b1; val_m[ld_tag] = ld_val; end
    if (ex_valid) begin rdy_m[ex_tag] = 1'b1; val_m[ex_tag] = ex_val; end
    if (ren_valid) rdy_m[ren_tag] = 1'b0;
    if (cmt_valid && cmt_rd != 0) begin
      rf_m[cmt_rd] = cmt_val;
      if (busy_m[cmt_rd] && tag_m[cmt_rd] == cmt_tag && !(ren_valid && ren_rd == cmt_rd))
        busy_m[cmt_rd] = 1'b0;
    end
    if (ren_valid && ren_rd != 0) begin
      busy_m[ren_rd] = 1'b1;
      tag_m[ren_rd]  = ren_tag;
    end
  endtask

  task automatic clear_inputs();
    req_valid = 0; ren_valid = 0; ex_valid = 0; ld_valid = 0; cmt_valid = 0;
  endtask

  // Driver: push the expectation, let the edge happen, update the model.
  task automatic step(input string req);
    if (req_valid) begin
      exp_q.push_back({resolve(req_rs1), resolve(req_rs2)});
      req_q.push_back(req);
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic ask(input logic [4:0] a, input logic [4:0] b);
    req_valid = 1; req_rs1 = a; req_rs2 = b;
  endtask

  // Monitor: compare every produced result with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [73:0] act;
      act = {out_rdy1, out_val1, out_tag1, out_rdy2, out_val2, out_tag2};
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected out_valid", act, '0);
      end else begin
        logic [73:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(act == e, r, act, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [73:0] snap;
    for (int i = 0; i < 32; i++) begin rf_m[i] = 0; busy_m[i] = 0; tag_m[i] = 0; end
    for (int i = 0; i < 16; i++) begin rdy_m[i] = 0; val_m[i] = 0; end
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_val1 == 0 && out_rdy1 == 0, "R1 reset outputs",
          {out_valid, out_val1}, 0);
    rst = 0;
    @(negedge clk);

    ask(5, 31); step("R1 fresh registers read zero");
    ask(0, 0);  step("R9 x0 at rest");

    cmt_valid = 1; cmt_rd = 5; cmt_tag = 3; cmt_val = 32'h1234; step("R11 write only");
    ask(5, 6); step("R2 unrenamed register value");

    ren_valid = 1; ren_rd = 7; ren_tag = 2; ask(7, 5); step("R10 same-cycle rename unseen");
    ask(7, 7); step("R10 R8 later request waits on tag");

    ex_valid = 1; ex_tag = 2; ex_val = 32'hAAAA0001; ask(7, 5); step("R4 execution bypass");
    ask(5, 7); step("R3 recorded result");

    ren_valid = 1; ren_rd = 8; ren_tag = 4; step("setup rename r8");
    ld_valid = 1; ld_tag = 4; ld_val = 32'hBBBB0002; ask(0, 8); step("R5 load bypass");

    ren_valid = 1; ren_rd = 9; ren_tag = 5; step("setup rename r9");
    cmt_valid = 1; cmt_rd = 9; cmt_tag = 5; cmt_val = 32'hCCCC0003; ask(9, 9); step("R6 retirement bypass");
    ask(9, 0); step("R11 retired register unrenamed");

    ren_valid = 1; ren_rd = 10; ren_tag = 6; step("setup rename r10");
    cmt_valid = 1; cmt_rd = 10; cmt_tag = 6; cmt_val = 32'hDDDD0004;
    ren_valid = 1; ren_rd = 10; ren_tag = 7; ask(10, 0); step("R6 retire with same-reg rename");
    ask(10, 10); step("R11 newer rename survives retirement");

    ren_valid = 1; ren_rd = 11; ren_tag = 8; step("setup rename r11");
    ex_valid = 1; ex_tag = 8; ex_val = 32'h1111;
    ld_valid = 1; ld_tag = 8; ld_val = 32'h2222;
    cmt_valid = 1; cmt_rd = 11; cmt_tag = 8; cmt_val = 32'h3333;
    ask(11, 11); step("R7 execution above load and retirement");

    ren_valid = 1; ren_rd = 12; ren_tag = 9; step("setup rename r12");
    ld_valid = 1; ld_tag = 9; ld_val = 32'h4444;
    cmt_valid = 1; cmt_rd = 12; cmt_tag = 9; cmt_val = 32'h5555;
    ask(12, 0); step("R7 load above retirement");

    ren_valid = 1; ren_rd = 13; ren_tag = 10; step("setup rename r13");
    ex_valid = 1; ex_tag = 10; ex_val = 32'h6666; step("setup result tag10");
    ex_valid = 1; ex_tag = 10; ex_val = 32'h7777; ask(13, 0); step("R7 recorded result above broadcast");

    ren_valid = 1; ren_rd = 14; ren_tag = 1; step("setup rename r14");
    ex_valid = 1; ex_tag = 9; ex_val = 32'h8888; ask(14, 0); step("R8 other tag does not match");

    ren_valid = 1; ren_rd = 0; ren_tag = 11; step("R9 rename of x0");
    cmt_valid = 1; cmt_rd = 0; cmt_tag = 11; cmt_val = 32'h9999; ask(0, 0); step("R9 x0 ignores retirement");
    ask(0, 0); step("R9 x0 after ignored writes");

    ren_valid = 1; ren_rd = 15; ren_tag = 2; step("R3 reallocate tag2");
    ask(15, 7); step("R3 reallocated tag forgets result");

    ask(13, 14); step("R12 hold setup");
    snap = {out_rdy1, out_val1, out_tag1, out_rdy2, out_val2, out_tag2};
    ask(3, 3); req_valid = 0; ex_valid = 1; ex_tag = 1; ex_val = 32'hFEED; step("R12 idle");
    check(out_valid == 0, "R12 valid drops", {73'h0, out_valid}, 0);
    check({out_rdy1, out_val1, out_tag1, out_rdy2, out_val2, out_tag2} == snap,
          "R12 outputs hold", {out_rdy1, out_val1, out_tag1, out_rdy2, out_val2, out_tag2}, snap);

    for (int n = 0; n < 2000; n++) begin
      req_valid = $urandom_range(0, 1);
      req_rs1 = 5'($urandom_range(0, 15));
      req_rs2 = 5'($urandom_range(0, 15));
      ex_valid = ($urandom_range(0, 3) == 0); ex_tag = 4'($urandom); ex_val = $urandom;
      ld_valid = ($urandom_range(0, 3) == 0); ld_tag = 4'($urandom); ld_val = $urandom;
      cmt_valid = ($urandom_range(0, 3) == 0); cmt_rd = 5'($urandom_range(0, 15));
      cmt_tag = ($urandom_range(0, 1) == 0) ? tag_m[cmt_rd] : 4'($urandom);
      cmt_val = $urandom;
      ren_valid = ($urandom_range(0, 2) == 0); ren_rd = 5'($urandom_range(0, 15));
      ren_tag = 4'($urandom);
      while ((ex_valid && ren_tag == ex_tag) || (ld_valid && ren_tag == ld_tag))
        ren_tag = ren_tag + 4'd1;
      step("R2-R11 random mix");
    end
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R12 every request answered", 74'(exp_q.size()), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule